// File: doc/BRIEF.md
# Shadow Highlight Pixel Compositor

This block decides the final colour of one display pixel each cycle. It receives a backdrop palette selection, one pixel from each of two background planes (called the front plane and the rear plane here), and one sprite pixel. Every layer pixel carries a 4-bit colour index, a 2-bit palette number and a priority bit. The block picks the visible layer from priority and transparency. It reads the chosen entry from a 64-entry palette memory that sits outside the block and answers reads in the same cycle. It then expands the 9-bit colour into a 12-bit output at one of three brightness levels.

A dimming mode can be switched on per pixel. In that mode, planes whose tiles are both low priority are darkened. Two reserved sprite codes are not drawn. Instead they darken or brighten the plane underneath, and the brightness state clamps at shadow and highlight. When the mode is off, every pixel is shown at normal brightness and the reserved codes are ordinary colours.

Top module: `shc_compositor`

## Requirements
- R1: A colour index of 0 is transparent in every layer and palette. The backdrop selection is shown only when no layer pixel is drawn, and it may name any entry, including one with index 0.
- R2: A layer bus is {priority[6], palette[5:4], index[3:0]}. The palette read address is palette*16 + index, and the backdrop selection is used as a 6-bit address directly.
- R3: The drawn layers are ranked front to back as follows: high sprite, high front plane, high rear plane, low sprite, low front plane, low rear plane, backdrop.
- R4: A pixel presented with pix_valid before clock edge N appears on out_rgb, with out_valid high, after edge N+1. Both outputs are 0 after reset.
- R5: With sh_en low, every pixel has normal brightness, and sprite codes palette 3 index 14 and 15 are drawn as colours.
- R6: With sh_en high, a plane or backdrop result is shadowed when both plane priority bits are low. A high-priority plane pixel prevents this even when it is transparent.
- R7: With sh_en high, a visible sprite over dark planes (both plane priorities low) is shadowed if its priority is low and normal if its priority is high.
- R8: With sh_en high, sprite code palette 3 index 15 is not drawn and forces shadow on the plane or backdrop result. A second shadow stays at shadow.
- R9: With sh_en high, sprite code palette 3 index 14 is not drawn and raises the plane or backdrop result by one level: shadow becomes normal and normal becomes highlight.
- R10: The shadow and highlight codes act only when the sprite priority is high or both plane priorities are low.
- R11: A visible sprite with index 14 in palettes 0 to 2 is always shown at normal brightness.
- R12: Palette data holds red in [2:0], green in [5:3] and blue in [8:6]. Each output nibble (red [3:0], green [7:4], blue [11:8]) is {0,c} for shadow, {c,0} for normal and {0,c}+7 for highlight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Layer inputs hold a pixel this cycle |
| sh_en | input | 1 | Dimming mode enable |
| bd_sel | input | 6 | Backdrop palette address |
| pa_pix | input | 7 | Front plane pixel |
| pb_pix | input | 7 | Rear plane pixel |
| sp_pix | input | 7 | Sprite pixel |
| pal_rd_addr | output | 6 | Palette memory read address |
| pal_rd_data | input | 9 | Palette memory data for pal_rd_addr, same cycle |
| out_valid | output | 1 | out_rgb holds a new pixel |
| out_rgb | output | 12 | Final colour at 4 bits per component |

## Verification
The block has two register stages. An input pixel presented before edge N drives the palette address after edge N, and its colour is due after edge N+1. The latency check therefore asserts pix_valid for a single cycle from idle. It then samples out_valid at the falling edges after N, N+1 and N+2 and expects low, high and low. Every pixel check holds its inputs for two rising edges and samples at the falling edge after the second one, where both the palette lookup and the brightness stage have settled.

// File: rtl/shc_pkg.sv
package shc_pkg;
   typedef enum logic [1:0] {
      LVL_SHADOW = 2'd0,
      LVL_NORMAL = 2'd1,
      LVL_HIGH   = 2'd2
   } lvl_e;
endpackage

// File: rtl/shc_layer_unpack.sv
module shc_layer_unpack #(
   parameter int IDX_W = 4,
   parameter int PAL_W = 2
) (
   input  logic [IDX_W+PAL_W:0] pix,
   output logic [IDX_W-1:0]     idx,
   output logic [PAL_W-1:0]     pal,
   output logic                 pri,
   output logic                 opaque
);
   localparam int PRI_BIT = IDX_W + PAL_W;

   assign idx    = pix[IDX_W-1:0];
   assign pal    = pix[PRI_BIT-1:IDX_W];
   assign pri    = pix[PRI_BIT];
   assign opaque = (pix[IDX_W-1:0] != '0);
endmodule

// File: rtl/shc_layer_resolve.sv
module shc_layer_resolve
   import shc_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter int PAL_W = 2
) (
   input  logic                   sh_en,
   input  logic [IDX_W+PAL_W-1:0] bd_sel,
   input  logic [IDX_W-1:0]       a_idx,
   input  logic [PAL_W-1:0]       a_pal,
   input  logic                   a_pri,
   input  logic                   a_opq,
   input  logic [IDX_W-1:0]       b_idx,
   input  logic [PAL_W-1:0]       b_pal,
   input  logic                   b_pri,
   input  logic                   b_opq,
   input  logic [IDX_W-1:0]       s_idx,
   input  logic [PAL_W-1:0]       s_pal,
   input  logic                   s_pri,
   input  logic                   s_opq,
   output logic [IDX_W+PAL_W-1:0] addr,
   output lvl_e                   level
);
   localparam logic [IDX_W-1:0] SH_CODE = '1;
   localparam logic [IDX_W-1:0] HL_CODE = SH_CODE - 1'b1;

   typedef enum logic [1:0] {WIN_BD, WIN_A, WIN_B, WIN_S} win_e;

   logic op_pal, op_sh, op_hl, s_draw, planes_dark, op_ok;
   win_e win;
   lvl_e base;

   assign op_pal      = sh_en && (s_pal == '1);
   assign op_sh       = op_pal && (s_idx == SH_CODE);
   assign op_hl       = op_pal && (s_idx == HL_CODE);
   assign s_draw      = s_opq && !op_sh && !op_hl;
   assign planes_dark = !a_pri && !b_pri;
   assign op_ok       = s_pri || planes_dark;

   always_comb begin
      if      (s_draw && s_pri) win = WIN_S;
      else if (a_opq && a_pri)  win = WIN_A;
      else if (b_opq && b_pri)  win = WIN_B;
      else if (s_draw)          win = WIN_S;
      else if (a_opq)           win = WIN_A;
      else if (b_opq)           win = WIN_B;
      else                      win = WIN_BD;
   end

   always_comb begin
      unique case (win)
         WIN_A:   addr = {a_pal, a_idx};
         WIN_B:   addr = {b_pal, b_idx};
         WIN_S:   addr = {s_pal, s_idx};
         default: addr = bd_sel;
      endcase
   end

   always_comb begin
      base = planes_dark ? LVL_SHADOW : LVL_NORMAL;
      if (!sh_en) begin
         level = LVL_NORMAL;
      end else if (win == WIN_S) begin
         if (s_idx == HL_CODE)          level = LVL_NORMAL;
         else if (planes_dark && !s_pri) level = LVL_SHADOW;
         else                            level = LVL_NORMAL;
      end else if (op_sh && op_ok) begin
         level = LVL_SHADOW;
      end else if (op_hl && op_ok) begin
         level = (base == LVL_SHADOW) ? LVL_NORMAL : LVL_HIGH;
      end else begin
         level = base;
      end
   end
endmodule

// File: rtl/shc_bright_apply.sv
module shc_bright_apply
   import shc_pkg::*;
#(
   parameter int COMP_W = 3,
   parameter int NCOMP  = 3
) (
   input  logic [COMP_W*NCOMP-1:0]     color,
   input  lvl_e                        level,
   output logic [(COMP_W+1)*NCOMP-1:0] rgb
);
   localparam logic [COMP_W:0] HL_OFS = (COMP_W+1)'((1 << COMP_W) - 1);

   for (genvar k = 0; k < NCOMP; k++) begin : g_comp
      logic [COMP_W-1:0] c;
      assign c = color[k*COMP_W +: COMP_W];
      always_comb begin
         unique case (level)
            LVL_SHADOW: rgb[k*(COMP_W+1) +: COMP_W+1] = {1'b0, c};
            LVL_HIGH:   rgb[k*(COMP_W+1) +: COMP_W+1] = {1'b0, c} + HL_OFS;
            default:    rgb[k*(COMP_W+1) +: COMP_W+1] = {c, 1'b0};
         endcase
      end
   end
endmodule

// File: rtl/shc_compositor.sv
module shc_compositor
   import shc_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int PAL_W  = 2,
   parameter int COMP_W = 3,
   parameter int NCOMP  = 3,
   localparam int ADDR_W  = IDX_W + PAL_W,
   localparam int LAYER_W = ADDR_W + 1,
   localparam int COL_W   = COMP_W * NCOMP,
   localparam int OUT_W   = (COMP_W + 1) * NCOMP
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pix_valid,
   input  logic               sh_en,
   input  logic [ADDR_W-1:0]  bd_sel,
   input  logic [LAYER_W-1:0] pa_pix,
   input  logic [LAYER_W-1:0] pb_pix,
   input  logic [LAYER_W-1:0] sp_pix,
   output logic [ADDR_W-1:0]  pal_rd_addr,
   input  logic [COL_W-1:0]   pal_rd_data,
   output logic               out_valid,
   output logic [OUT_W-1:0]   out_rgb
);
   if (IDX_W < 2) begin : g_chk_idx
      $error("IDX_W must be at least 2 to hold the operator codes");
   end
   if (PAL_W < 1) begin : g_chk_pal
      $error("PAL_W must be at least 1");
   end
   if (COMP_W < 1 || NCOMP < 1) begin : g_chk_comp
      $error("colour component geometry must be non-empty");
   end

   localparam int NL = 3;

   logic [LAYER_W-1:0] l_pix [NL];
   logic [IDX_W-1:0]   l_idx [NL];
   logic [PAL_W-1:0]   l_pal [NL];
   logic               l_pri [NL];
   logic               l_opq [NL];

   assign l_pix[0] = pa_pix;
   assign l_pix[1] = pb_pix;
   assign l_pix[2] = sp_pix;

   for (genvar i = 0; i < NL; i++) begin : g_layer
      shc_layer_unpack #(.IDX_W(IDX_W), .PAL_W(PAL_W)) i_unpack (
         .pix    (l_pix[i]),
         .idx    (l_idx[i]),
         .pal    (l_pal[i]),
         .pri    (l_pri[i]),
         .opaque (l_opq[i])
      );
   end

   logic [ADDR_W-1:0] res_addr;
   lvl_e              res_level;

   shc_layer_resolve #(.IDX_W(IDX_W), .PAL_W(PAL_W)) i_resolve (
      .sh_en (sh_en),  .bd_sel(bd_sel),
      .a_idx (l_idx[0]), .a_pal(l_pal[0]), .a_pri(l_pri[0]), .a_opq(l_opq[0]),
      .b_idx (l_idx[1]), .b_pal(l_pal[1]), .b_pri(l_pri[1]), .b_opq(l_opq[1]),
      .s_idx (l_idx[2]), .s_pal(l_pal[2]), .s_pri(l_pri[2]), .s_opq(l_opq[2]),
      .addr  (res_addr), .level(res_level)
   );

   logic              s1_valid;
   logic [ADDR_W-1:0] s1_addr;
   lvl_e              s1_level;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_addr  <= '0;
         s1_level <= LVL_NORMAL;
      end else begin
         s1_valid <= pix_valid;
         if (pix_valid) begin
            s1_addr  <= res_addr;
            s1_level <= res_level;
         end
      end
   end

   assign pal_rd_addr = s1_addr;

   logic [OUT_W-1:0] rgb_next;

   shc_bright_apply #(.COMP_W(COMP_W), .NCOMP(NCOMP)) i_bright (
      .color (pal_rd_data),
      .level (s1_level),
      .rgb   (rgb_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_rgb   <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid) out_rgb <= rgb_next;
      end
   end

   localparam logic [IDX_W-1:0] SH_CODE = '1;
   localparam logic [IDX_W-1:0] HL_CODE = SH_CODE - 1'b1;

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> ##2 out_valid); // R4
   AST_BACKDROP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && res_addr[IDX_W-1:0] == '0) |-> (res_addr == bd_sel)); // R1
   AST_MODE_OFF_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && !sh_en) |-> (res_level == LVL_NORMAL)); // R5
   AST_HIGH_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && res_level == LVL_HIGH) |->
      (sh_en && sp_pix[ADDR_W-1:IDX_W] == '1 && sp_pix[IDX_W-1:0] == HL_CODE)); // R9
   AST_SHADOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_valid && res_level == LVL_SHADOW) |->
      (sh_en && ((!pa_pix[ADDR_W] && !pb_pix[ADDR_W]) ||
                 (sp_pix[ADDR_W-1:IDX_W] == '1 && sp_pix[IDX_W-1:0] == SH_CODE)))); // R6
endmodule

// File: tb/test_shc_compositor.sv
`timescale 1ns/1ps
module test_shc_compositor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pix_valid = 1'b0;
   logic        sh_en = 1'b0;
   logic [5:0]  bd_sel = '0;
   logic [6:0]  pa_pix = '0, pb_pix = '0, sp_pix = '0;
   logic [5:0]  pal_rd_addr;
   logic [8:0]  pal_rd_data;
   logic        out_valid;
   logic [11:0] out_rgb;
   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   function automatic logic [8:0] pal_f(input logic [5:0] a);
      logic [8:0] w;
      w = {3'b0, a} * 9'd73 + 9'd21;
      return w ^ {a[2:0], a};
   endfunction

   always_comb pal_rd_data = pal_f(pal_rd_addr);

   shc_compositor i_shc_compositor (
      .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .sh_en(sh_en),
      .bd_sel(bd_sel), .pa_pix(pa_pix), .pb_pix(pb_pix), .sp_pix(sp_pix),
      .pal_rd_addr(pal_rd_addr), .pal_rd_data(pal_rd_data),
      .out_valid(out_valid), .out_rgb(out_rgb)
   );

   // Reference model: level -1 shadow, 0 normal, +1 highlight
   function automatic logic [11:0] model(input logic sh, input logic [5:0] bd,
                                         input logic [6:0] a, input logic [6:0] b,
                                         input logic [6:0] s);
      logic [5:0] adr;
      logic [8:0] col;
      logic [11:0] r;
      logic sop, hop, sdraw, dark, spr_win;
      int lvl;
      sop   = sh && s[5:4] == 2'd3 && s[3:0] == 4'd15;
      hop   = sh && s[5:4] == 2'd3 && s[3:0] == 4'd14;
      sdraw = (s[3:0] != 0) && !sop && !hop;
      dark  = !a[6] && !b[6];
      spr_win = 1'b0;
      if (sdraw && s[6])            begin adr = s[5:0]; spr_win = 1'b1; end
      else if (a[3:0] != 0 && a[6]) adr = a[5:0];
      else if (b[3:0] != 0 && b[6]) adr = b[5:0];
      else if (sdraw)               begin adr = s[5:0]; spr_win = 1'b1; end
      else if (a[3:0] != 0)         adr = a[5:0];
      else if (b[3:0] != 0)         adr = b[5:0];
      else                          adr = bd;
      lvl = 0;
      if (sh) begin
         if (spr_win) lvl = (s[3:0] != 4'd14 && dark && !s[6]) ? -1 : 0;
         else begin
            lvl = dark ? -1 : 0;
            if (s[6] || dark) begin
               if (sop) lvl = -1;
               if (hop) lvl = lvl + 1;
            end
         end
      end
      col = pal_f(adr);
      for (int k = 0; k < 3; k++) begin
         int c;
         c = int'(col[k*3 +: 3]);
         if (lvl < 0)      r[k*4 +: 4] = 4'(c);
         else if (lvl > 0) r[k*4 +: 4] = 4'(c + 7);
         else              r[k*4 +: 4] = 4'(c * 2);
      end
      return r;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_vec(input string req, input logic sh, input logic [5:0] bd,
                          input logic [6:0] a, input logic [6:0] b, input logic [6:0] s);
      @(negedge clk);
      sh_en = sh; bd_sel = bd; pa_pix = a; pb_pix = b; sp_pix = s; pix_valid = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk({req, " valid"}, 32'(out_valid), 32'd1);
      chk(req, 32'(out_rgb), 32'(model(sh, bd, a, b, s)));
   endtask

   function automatic logic [12:0] col_nib(input logic [5:0] adr, input int lvl);
      logic [8:0] c;
      c = pal_f(adr);
      if (lvl < 0) return {1'b0, 1'b0, c[8:6], 1'b0, c[5:3], 1'b0, c[2:0]};
      if (lvl > 0) return {1'b0, 4'({1'b0,c[8:6]} + 4'd7), 4'({1'b0,c[5:3]} + 4'd7), 4'({1'b0,c[2:0]} + 4'd7)};
      return {1'b0, c[8:6], 1'b0, c[5:3], 1'b0, c[2:0], 1'b0};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL R4 watchdog actual=hang expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(1234));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk("R4 reset valid", 32'(out_valid), 32'd0);
      chk("R4 reset rgb", 32'(out_rgb), 32'd0);

      // R4 latency from idle
      repeat (3) @(negedge clk);
      sh_en = 1'b0; bd_sel = 6'd9; pa_pix = 7'h00; pb_pix = 7'h00; sp_pix = 7'h00;
      pix_valid = 1'b1;
      @(negedge clk) pix_valid = 1'b0;
      chk("R4 lat edge N", 32'(out_valid), 32'd0);
      @(negedge clk);
      chk("R4 lat edge N+1", 32'(out_valid), 32'd1);
      chk("R4 lat rgb", 32'(out_rgb), 32'(col_nib(6'd9, 0)));
      @(negedge clk);
      chk("R4 lat edge N+2", 32'(out_valid), 32'd0);

      // R1 all transparent, backdrop with index 0 shown
      run_vec("R1 backdrop idx0", 1'b0, 6'h20, 7'h50, 7'h60, 7'h70);
      chk("R1 backdrop colour", 32'(out_rgb), 32'(col_nib(6'h20, 0)));
      // R2 address from palette and index of front plane
      run_vec("R2 addr", 1'b0, 6'h00, 7'h25, 7'h00, 7'h00);
      chk("R2 entry 37", 32'(out_rgb), 32'(col_nib(6'd37, 0)));
      // R3 high rear plane beats low sprite
      run_vec("R3 hi B over lo S", 1'b0, 6'h0, 7'h03, 7'h4A, 7'h17);
      chk("R3 rear entry", 32'(out_rgb), 32'(col_nib(6'h0A, 0)));
      // R3 low sprite beats low front plane
      run_vec("R3 lo S over lo A", 1'b0, 6'h0, 7'h13, 7'h0A, 7'h27);
      chk("R3 sprite entry", 32'(out_rgb), 32'(col_nib(6'h27, 0)));
      // R5 mode off: shadow code drawn as colour, normal level
      run_vec("R5 code drawn", 1'b0, 6'h0, 7'h01, 7'h02, 7'h3F);
      chk("R5 entry 63", 32'(out_rgb), 32'(col_nib(6'h3F, 0)));
      // R6 dark planes shadowed
      run_vec("R6 dark", 1'b1, 6'h0, 7'h05, 7'h02, 7'h00);
      chk("R6 shadow", 32'(out_rgb), 32'(col_nib(6'h05, -1)));
      // R6 transparent high rear tile prevents shadow
      run_vec("R6 hi transparent", 1'b1, 6'h0, 7'h05, 7'h40, 7'h00);
      chk("R6 normal", 32'(out_rgb), 32'(col_nib(6'h05, 0)));
      // R7 low sprite over dark planes shadowed, high sprite normal
      run_vec("R7 lo sprite", 1'b1, 6'h0, 7'h05, 7'h02, 7'h23);
      chk("R7 lo shadow", 32'(out_rgb), 32'(col_nib(6'h23, -1)));
      run_vec("R7 hi sprite", 1'b1, 6'h0, 7'h05, 7'h02, 7'h63);
      chk("R7 hi normal", 32'(out_rgb), 32'(col_nib(6'h23, 0)));
      // R8 shadow code over dark planes stays shadow, over normal plane goes shadow
      run_vec("R8 double shadow", 1'b1, 6'h0, 7'h05, 7'h02, 7'h3F);
      chk("R8 clamp", 32'(out_rgb), 32'(col_nib(6'h05, -1)));
      run_vec("R8 shadow op", 1'b1, 6'h0, 7'h45, 7'h02, 7'h7F);
      chk("R8 op", 32'(out_rgb), 32'(col_nib(6'h05, -1)));
      // R9 highlight over shadow gives normal; over normal gives highlight
      run_vec("R9 cancel", 1'b1, 6'h0, 7'h05, 7'h02, 7'h3E);
      chk("R9 normal", 32'(out_rgb), 32'(col_nib(6'h05, 0)));
      run_vec("R9 highlight", 1'b1, 6'h0, 7'h45, 7'h02, 7'h7E);
      chk("R9 high", 32'(out_rgb), 32'(col_nib(6'h05, 1)));
      // R10 plane above low sprite blocks operator
      run_vec("R10 blocked", 1'b1, 6'h0, 7'h45, 7'h02, 7'h3E);
      chk("R10 normal", 32'(out_rgb), 32'(col_nib(6'h05, 0)));
      // R11 sprite index 14 palette 1 not shadowed
      run_vec("R11 idx14", 1'b1, 6'h0, 7'h05, 7'h02, 7'h1E);
      chk("R11 normal", 32'(out_rgb), 32'(col_nib(6'h1E, 0)));
      // R12 backdrop at highlight via operator, check nibble encoding
      run_vec("R12 bd high", 1'b1, 6'h2D, 7'h40, 7'h00, 7'h7E);
      chk("R12 encode", 32'(out_rgb), 32'(col_nib(6'h2D, 1)));

      // Random mix, biased toward operator codes and transparency (R3 R6 R9 R12)
      for (int n = 0; n < 300; n++) begin
         logic [6:0] a, b, s;
         a = 7'($urandom); b = 7'($urandom); s = 7'($urandom);
         if ($urandom % 4 == 0) a[3:0] = 4'd0;
         if ($urandom % 4 == 0) b[3:0] = 4'd0;
         if ($urandom % 4 == 0) s[3:0] = 4'd0;
         if ($urandom % 3 == 0) s[5:0] = ($urandom % 2) ? 6'h3F : 6'h3E;
         run_vec("R3 random", 1'($urandom), 6'($urandom), a, b, s);
      end

      @(negedge clk) pix_valid = 1'b0;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule